// File: doc/BRIEF.md
# Fractional Pixel Clock Divider

This block produces a pixel clock from a master clock. The pixel clock can be the master clock itself, two thirds of it, one half of it or one quarter of it. In the two-thirds setting, three master cycles hold exactly two pixel periods, so 12 MHz becomes 8 MHz. To get this ratio the output must be able to change in the middle of a master cycle. The block therefore runs from a reference clock at twice the master frequency. A phase bit marks which half of the master cycle is current, and the block produces this bit itself.

The divider state is a three-bit count of master cycles together with the phase bit. Each mode wraps its count at its own terminal value. The output level is decoded from the count, the phase and the active mode, and then registered. The pixel clock and the master phase both come straight from flip-flops. The select input is only taken at the end of a full sequence, so each sequence is always completed before the divide ratio changes.

Top module: `pclk_frac_div`

## Requirements
- R1: While `rst` is high, and on the first sample after it falls, `pix_clk` is 0 and `mphase` is 0. The divider is at the start of a sequence, and the mode is loaded from `div_sel` during reset.
- R2: `mphase` inverts on every rising edge of `clk` when not in reset. It is 0 in the first half of each master cycle and 1 in the second half.
- R3: Select encoding 2'b00 is divide by 1. `pix_clk` follows `mphase`, giving a sequence of two half-cycles: low, then high.
- R4: Select encoding 2'b01 is divide by 3/2. The sequence is six half-cycles long, with the pattern low, low, high, low, low, high. It has four output transitions per sequence and a duty of one third high.
- R5: Select encoding 2'b10 is divide by 2. The sequence is four half-cycles long, with the pattern low, low, high, high.
- R6: Select encoding 2'b11 is divide by 4. The sequence is eight half-cycles long: four low, then four high.
- R7: A change of `div_sel` has no effect until the current sequence ends. The value present on the `clk` edge that ends the sequence becomes the new mode. The next sequence then starts from its first half-cycle, with `pix_clk` low and `mphase` 0.
- R8: In divide-by-3/2 mode, consecutive rising edges of `pix_clk` are exactly three `clk` cycles apart. This is one and a half master cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock at twice the master frequency |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 2 | Divide-ratio select (00 /1, 01 /1.5, 10 /2, 11 /4) |
| pix_clk | output | 1 | Selected pixel clock, registered |
| mphase | output | 1 | Master clock phase: 0 first half, 1 second half |

## Verification
The checker assumes that `div_sel` is a clean synchronous value on each `clk` edge. It also assumes that the mode register only changes on the wrap edge. Its per-mode properties therefore read the internal active mode rather than `div_sel`. The stimulus changes `div_sel` only on falling edges of `clk`. It holds reset for several cycles before releasing it. Some mode changes are placed deliberately in the middle of a sequence, so the hold-until-wrap rule is exercised rather than assumed. The bench model counts half-cycle positions directly, which is independent of the master-cycle counter inside the design.

// File: rtl/pclk_div_pkg.sv
package pclk_div_pkg;

  localparam int CNT_W = 3;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    DIV_1  = 2'b00,
    DIV_3H = 2'b01,
    DIV_2  = 2'b10,
    DIV_4  = 2'b11
  } div_mode_e;

  // last master-cycle count of a sequence for each mode
  function automatic logic [CNT_W-1:0] last_count(input div_mode_e m);
    case (m)
      DIV_1:   last_count = CNT_W'(0);
      DIV_3H:  last_count = CNT_W'(2);
      DIV_2:   last_count = CNT_W'(1);
      default: last_count = CNT_W'(3);
    endcase
  endfunction

endpackage

// File: rtl/pclk_phase_gen.sv
module pclk_phase_gen (
  input  logic clk,
  input  logic rst,
  output logic ph_q,
  output logic ph_nxt
);
  always_comb ph_nxt = rst ? 1'b0 : ~ph_q;

  always_ff @(posedge clk) begin
    ph_q <= ph_nxt;
  end
endmodule

// File: rtl/pclk_seq_ctr.sv
module pclk_seq_ctr
  import pclk_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ph_q,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] cnt_q,
  output div_mode_e        mode_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output div_mode_e        mode_nxt
);
  logic wrap;

  always_comb begin
    wrap     = ph_q && (cnt_q == last_count(mode_q));
    cnt_nxt  = cnt_q;
    mode_nxt = mode_q;
    if (rst) begin
      cnt_nxt  = '0;
      mode_nxt = div_mode_e'(sel);
    end else if (wrap) begin
      cnt_nxt  = '0;
      mode_nxt = div_mode_e'(sel);
    end else if (ph_q) begin
      cnt_nxt  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    cnt_q  <= cnt_nxt;
    mode_q <= mode_nxt;
  end
endmodule

// File: rtl/pclk_pattern.sv
module pclk_pattern
  import pclk_div_pkg::*;
(
  input  div_mode_e        mode,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ph,
  output logic             level
);
  always_comb begin
    case (mode)
      DIV_1:   level = ph;
      DIV_3H:  level = ((cnt == CNT_W'(1)) && !ph) || ((cnt == CNT_W'(2)) && ph);
      DIV_2:   level = cnt[0];
      default: level = cnt[1];
    endcase
  end
endmodule

// File: rtl/pclk_frac_div.sv
module pclk_frac_div
  import pclk_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] div_sel,
  output logic             pix_clk,
  output logic             mphase
);
  logic             ph_q, ph_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  div_mode_e        act_mode, mode_nxt;
  logic             lvl_nxt;
  logic             pix_q;

  pclk_phase_gen u_phase (
    .clk(clk), .rst(rst), .ph_q(ph_q), .ph_nxt(ph_nxt)
  );

  pclk_seq_ctr u_seq (
    .clk(clk), .rst(rst), .ph_q(ph_q), .sel(div_sel),
    .cnt_q(cnt_q), .mode_q(act_mode), .cnt_nxt(cnt_nxt), .mode_nxt(mode_nxt)
  );

  pclk_pattern u_pat (
    .mode(mode_nxt), .cnt(cnt_nxt), .ph(ph_nxt), .level(lvl_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) pix_q <= 1'b0;
    else     pix_q <= lvl_nxt;
  end

  assign pix_clk = pix_q;
  assign mphase  = ph_q;
endmodule

// File: rtl/pclk_frac_div_chk.sv
module pclk_frac_div_chk
  import pclk_div_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             pix_clk,
  input logic             mphase,
  input div_mode_e        act_mode,
  input logic [CNT_W-1:0] cnt
);
  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> (!pix_clk && !mphase && cnt == '0));

  assert_phase_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    mphase |=> !mphase);

  assert_phase_rise_R2: assert property (@(posedge clk) disable iff (rst)
    !mphase |=> mphase);

  assert_follow_phase_R3: assert property (@(posedge clk) disable iff (rst)
    (act_mode == DIV_1) |-> (pix_clk == mphase));

  assert_short_high_R4: assert property (@(posedge clk) disable iff (rst)
    (act_mode == DIV_3H && pix_clk) |=> !pix_clk);

  assert_half_toggle_R5: assert property (@(posedge clk) disable iff (rst)
    (act_mode == DIV_2 && mphase) |=> (pix_clk != $past(pix_clk)));

  assert_half_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (act_mode == DIV_2 && !mphase) |=> $stable(pix_clk));

  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(mphase && cnt == last_count(act_mode)) |=> $stable(act_mode));

  assert_wrap_start_R7: assert property (@(posedge clk) disable iff (rst)
    (mphase && cnt == last_count(act_mode)) |=> (cnt == '0 && !mphase && !pix_clk));
endmodule

bind pclk_frac_div pclk_frac_div_chk u_chk (
  .clk(clk), .rst(rst), .pix_clk(pix_clk), .mphase(mphase),
  .act_mode(act_mode), .cnt(cnt_q)
);

// File: tb/tb_pclk_frac_div.sv
module tb_pclk_frac_div;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] div_sel = 2'b00;
  logic       pix_clk, mphase;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state: half-cycle index within the sequence and active mode
  int       m_idx = 0;
  logic [1:0] m_mode = 2'b00;

  pclk_frac_div dut (
    .clk(clk), .rst(rst), .div_sel(div_sel), .pix_clk(pix_clk), .mphase(mphase)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int seq_len(input logic [1:0] m);
    case (m)
      2'b00: return 2;
      2'b01: return 6;
      2'b10: return 4;
      default: return 8;
    endcase
  endfunction

  function automatic logic exp_pix(input logic [1:0] m, input int i);
    case (m)
      2'b00: return (i == 1);
      2'b01: return (i == 2) || (i == 5);
      2'b10: return (i >= 2);
      default: return (i >= 4);
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // advance one reference cycle, update model, compare at falling edge
  task automatic step(input string req);
    @(posedge clk);
    if (rst) begin
      m_idx = 0; m_mode = div_sel;
    end else if (m_idx == seq_len(m_mode) - 1) begin
      m_idx = 0; m_mode = div_sel;
    end else begin
      m_idx++;
    end
    @(negedge clk);
    check(req, pix_clk, exp_pix(m_mode, m_idx), "pix_clk");
    check("R2", mphase, logic'(m_idx % 2), "mphase");
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; div_sel = 2'b00;
    for (int i = 0; i < 4; i++) step("R1");
    rst = 1'b0;
    check("R1", pix_clk, 1'b0, "pix_clk after reset");
    check("R1", mphase, 1'b0, "mphase after reset");
  endtask

  task automatic t_div1();
    for (int i = 0; i < 8; i++) step("R3");
  endtask

  task automatic go_mode(input logic [1:0] m, input string req);
    // request mode and run until model has it active at sequence start
    div_sel = m;
    while (!(m_mode == m && m_idx == 0)) step(req);
  endtask

  task automatic t_div32();
    int rises, toggles, last_rise, gap_ok;
    logic prev;
    go_mode(2'b01, "R4");
    prev = pix_clk; rises = 0; toggles = 0; last_rise = -1; gap_ok = 1;
    for (int i = 1; i <= 24; i++) begin
      step("R4");
      if (pix_clk != prev) toggles++;
      if (pix_clk && !prev) begin
        if (last_rise >= 0) check("R8", 1'b1, logic'((i - last_rise) == 3), "rise spacing of 3");
        last_rise = i; rises++;
      end
      prev = pix_clk;
    end
    check("R4", 1'b1, logic'(toggles == 16), "16 toggles over four sequences");
    check("R8", 1'b1, logic'(rises == 8), "8 rising edges over 24 cycles");
  endtask

  task automatic t_div2();
    go_mode(2'b10, "R5");
    for (int i = 0; i < 12; i++) step("R5");
  endtask

  task automatic t_div4();
    go_mode(2'b11, "R6");
    for (int i = 0; i < 16; i++) step("R6");
  endtask

  task automatic t_switch();
    go_mode(2'b11, "R7");
    step("R7"); step("R7"); step("R7");  // idx 3
    div_sel = 2'b10;                      // request mid-sequence
    for (int i = 0; i < 4; i++) begin
      step("R7");
      check("R7", pix_clk, 1'b1, "divide-by-4 high half kept");
    end
    step("R7"); // wrap: new sequence starts
    check("R7", pix_clk, 1'b0, "new sequence starts low");
    check("R7", mphase, 1'b0, "new sequence phase 0");
    for (int i = 0; i < 8; i++) step("R7");
    div_sel = 2'b00;
    step("R7");
    div_sel = 2'b01;
    for (int i = 0; i < 12; i++) step("R7");
  endtask

  initial begin
    t_reset();
    t_div1();
    t_div32();
    t_div2();
    t_div4();
    t_switch();
    go_mode(2'b00, "R3");
    t_div1();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule